// File: doc/BRIEF.md
# Frame Pulse Generator

This block turns a synchronous clock into an 8 kHz frame reference. A free-running period counter divides the clock by the number of clock cycles in one 125 µs frame. An output shaper then drives the frame line in one of two shapes: a square wave that is high for the first half of each frame, or a short high-going pulse at the start of each frame.

The pulse length comes from a small 8-bit width register. It is written through a data-and-strobe port and can always be read back. Only the low four bits hold the width. A write of zero is stored as one, so the pulse never disappears. The shape and width in use are captured only at frame boundaries, so a change made part-way through a frame never cuts a pulse short or stretches it.

The clock frequency and frame rate are parameters. The frame length in clocks is their quotient; the defaults are a 512 kHz clock and 64 clocks per frame. The asynchronous active-low reset is released through a two-stage synchroniser. The first count step therefore comes on the third rising edge after the reset pin is released.

Top module: `frame_pulse_gen`

## Requirements
- R1: Every frame lasts PERIOD = CLK_HZ / FRAME_HZ clocks (64 by default). The output is high on the first clock of every frame and low on the last clock of every frame.
- R2: In square shape, the output is high for clock indexes 0 to PERIOD/2 - 1 of the frame and low for the rest.
- R3: In pulse shape, the output is high for exactly W clocks from the start of the frame, where W is the active width.
- R4: A strobed write stores data bits 3..0 as the width on the next edge. A written value of 0 is stored as 1, so the stored width is always between 1 and 15.
- R5: Readback bits 7..4 are always 0, whatever was written to them. Bits 3..0 show the stored width.
- R6: While reset is asserted, the readback is 8'h01 and the output is high: square shape at frame index 0.
- R7: The shape input and the stored width are sampled only on the last clock of a frame. They are used for the whole of the next frame, so a mid-frame change has no effect until the following frame starts.
- R8: Shape input 2'b01 selects pulse shape. The values 2'b00, 2'b10 and 2'b11 all select square shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sync | input | 1 | Synchronous clock that drives the frame counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the width register |
| wr_data | input | 8 | Write data for the width register; bits 3..0 carry the width |
| shape_sel | input | 2 | Output shape select: 2'b01 is pulse, any other value is square |
| width_rd | output | 8 | Readback of the width register |
| frame_out | output | 1 | 8 kHz frame output |

## Verification
The assertions assume three things:
- Reset is applied before the first clock edge.
- The shape and write inputs change only away from the rising edge.
- The frame length is longer than twice the largest width, so every pulse ends inside its frame.

The stimulus keeps to these limits. It drives every input on the falling edge and uses the default 64-clock frame, in which a 15-clock pulse always fits. Random shape codes and occasional writes, including zero and values with the upper nibble set, are mixed with directed mid-frame changes and a second reset taken part-way through a frame.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  typedef enum logic [1:0] {
    SEL_SQUARE  = 2'b00,
    SEL_PULSE   = 2'b01,
    SEL_SPARE_A = 2'b10,
    SEL_SPARE_B = 2'b11
  } shape_sel_e;

  typedef enum logic {
    SHAPE_SQUARE = 1'b0,
    SHAPE_PULSE  = 1'b1
  } shape_e;

  function automatic shape_e decode_shape(input logic [1:0] sel);
    return (shape_sel_e'(sel) == SEL_PULSE) ? SHAPE_PULSE : SHAPE_SQUARE;
  endfunction

endpackage

// File: rtl/fpg_width_reg.sv
module fpg_width_reg #(
  parameter int REG_W   = 8,
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [FIELD_W-1:0] width_o,
  output logic [REG_W-1:0]   rd_o
);

  localparam logic [FIELD_W-1:0] WIDTH_MIN = FIELD_W'(1);

  logic [FIELD_W-1:0] width_q;
  logic [FIELD_W-1:0] width_d;
  logic [FIELD_W-1:0] field_in;

  assign field_in = wr_data[FIELD_W-1:0];

  always_comb begin
    width_d = width_q;
    if (wr_en) begin
      width_d = (field_in == '0) ? WIDTH_MIN : field_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= WIDTH_MIN;
    end else if (wr_en) begin
      width_q <= width_d;
    end
  end

  assign width_o = width_q;
  assign rd_o    = {{(REG_W-FIELD_W){1'b0}}, width_q};

  a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    width_q != '0);

  a_r4_zero_maps_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FIELD_W-1:0] == '0) |=> (width_o == WIDTH_MIN));

  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(width_o));

endmodule

// File: rtl/fpg_period_cnt.sv
module fpg_period_cnt #(
  parameter int PERIOD = 64,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_LAST);

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (cnt_o == '0));

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CNT_LAST);

endmodule

// File: rtl/fpg_shaper.sv
module fpg_shaper
  import fpg_pkg::*;
#(
  parameter int PERIOD  = 64,
  parameter int CNT_W   = 6,
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_last,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [FIELD_W-1:0] width_i,
  input  logic [1:0]         sel_i,
  output logic               out_o
);

  localparam int CMP_W = (CNT_W > FIELD_W) ? CNT_W : FIELD_W;
  localparam logic [CMP_W-1:0] HALF = CMP_W'(PERIOD / 2);

  shape_e             shape_q, shape_d;
  logic [FIELD_W-1:0] act_w_q, act_w_d;
  logic [CMP_W-1:0]   cnt_ext;
  logic [CMP_W-1:0]   w_ext;
  logic               sq_level;
  logic               pu_level;

  always_comb begin
    shape_d = shape_q;
    act_w_d = act_w_q;
    if (frame_last) begin
      shape_d = decode_shape(sel_i);
      act_w_d = width_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q <= SHAPE_SQUARE;
      act_w_q <= FIELD_W'(1);
    end else if (frame_last) begin
      shape_q <= shape_d;
      act_w_q <= act_w_d;
    end
  end

  assign cnt_ext  = CMP_W'(cnt_i);
  assign w_ext    = CMP_W'(act_w_q);
  assign sq_level = (cnt_ext < HALF);
  assign pu_level = (cnt_ext < w_ext);

  always_comb begin
    case (shape_q)
      SHAPE_PULSE: out_o = pu_level;
      default:     out_o = sq_level;
    endcase
  end

  a_r7_width_held_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(act_w_q));

  a_r7_shape_held_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(shape_q));

  a_r3_pulse_ends_at_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_o) && shape_q == SHAPE_PULSE) |-> (cnt_ext == w_ext));

  a_r2_square_ends_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_o) && shape_q == SHAPE_SQUARE) |-> (cnt_ext == HALF));

endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
  import fpg_pkg::*;
#(
  parameter int CLK_HZ   = 512000,
  parameter int FRAME_HZ = 8000,
  parameter int REG_W    = 8,
  parameter int FIELD_W  = 4
) (
  input  logic             clk_sync,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       shape_sel,
  output logic [REG_W-1:0] width_rd,
  output logic             frame_out
);

  localparam int PERIOD = CLK_HZ / FRAME_HZ;
  localparam int CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [CNT_W-1:0]   cnt;
  logic               frame_last;
  logic [FIELD_W-1:0] width_st;

  always_ff @(posedge clk_sync or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  fpg_width_reg #(
    .REG_W   (REG_W),
    .FIELD_W (FIELD_W)
  ) u_width (
    .clk     (clk_sync),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .width_o (width_st),
    .rd_o    (width_rd)
  );

  fpg_period_cnt #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W)
  ) u_cnt (
    .clk    (clk_sync),
    .rst_n  (rst_int_n),
    .cnt_o  (cnt),
    .last_o (frame_last)
  );

  fpg_shaper #(
    .PERIOD  (PERIOD),
    .CNT_W   (CNT_W),
    .FIELD_W (FIELD_W)
  ) u_shape (
    .clk        (clk_sync),
    .rst_n      (rst_int_n),
    .frame_last (frame_last),
    .cnt_i      (cnt),
    .width_i    (width_st),
    .sel_i      (shape_sel),
    .out_o      (frame_out)
  );

  a_r1_frame_start_high: assert property (@(posedge clk_sync) disable iff (!rst_int_n)
    frame_last |=> frame_out);

  a_r1_frame_end_low: assert property (@(posedge clk_sync) disable iff (!rst_int_n)
    frame_last |-> !frame_out);

  a_r5_reserved_zero: assert property (@(posedge clk_sync) disable iff (!rst_int_n)
    $past(wr_en) |-> (width_rd[REG_W-1:FIELD_W] == '0));

endmodule

// File: tb/test_frame_pulse_gen.sv
module test_frame_pulse_gen;

  localparam int P = 512000 / 8000;

  logic       clk_sync = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [1:0] shape_sel;
  logic [7:0] width_rd;
  logic       frame_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // bench model state
  int       m_sync;
  int       m_cnt;
  bit       m_pulse;
  int       m_aw;
  int       m_stored;
  bit [1:0] m_sel;

  always #4 clk_sync = ~clk_sync;

  frame_pulse_gen i_frame_pulse_gen (
    .clk_sync  (clk_sync),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .shape_sel (shape_sel),
    .width_rd  (width_rd),
    .frame_out (frame_out)
  );

  function automatic bit exp_level(int c, bit pulse, int w);
    return pulse ? (c < w) : (c < P / 2);
  endfunction

  function automatic int sanitize(logic [7:0] d);
    return (d[3:0] == 4'd0) ? 1 : int'(d[3:0]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sync = 0; m_cnt = 0; m_pulse = 1'b0; m_aw = 1; m_stored = 1;
  endtask

  task automatic check_outputs();
    bit e;
    e = exp_level(m_cnt, m_pulse, m_aw);
    if (m_cnt == 0 || m_cnt == P - 1)
      chk(frame_out == e, "R1", frame_out, e);
    else if (m_aw != m_stored || m_pulse != (m_sel == 2'b01))
      chk(frame_out == e, "R7", frame_out, e);
    else if (m_pulse)
      chk(frame_out == e, "R3", frame_out, e);
    else if (m_sel != 2'b00)
      chk(frame_out == e, "R8", frame_out, e);
    else
      chk(frame_out == e, "R2", frame_out, e);
    chk(width_rd[3:0] == 4'(m_stored), "R4", width_rd[3:0], m_stored);
    chk(width_rd[7:4] == 4'd0, "R5", width_rd[7:4], 0);
  endtask

  task automatic cycle(bit we, logic [7:0] d, logic [1:0] sel);
    int nstored;
    check_outputs();
    wr_en = we; wr_data = d; shape_sel = sel;
    m_sel = sel;
    if (m_sync < 2) begin
      m_sync++;
    end else begin
      nstored = we ? sanitize(d) : m_stored;
      if (m_cnt == P - 1) begin
        m_aw = m_stored; m_pulse = (sel == 2'b01); m_cnt = 0;
      end else begin
        m_cnt++;
      end
      m_stored = nstored;
    end
    @(negedge clk_sync);
  endtask

  task automatic run_to(int target, logic [1:0] sel);
    while (m_sync < 2 || m_cnt != target) cycle(1'b0, 8'h00, sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk_sync);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; shape_sel = 2'b00;
    m_sel = 2'b00;
    model_reset();
    repeat (3) @(negedge clk_sync);
    // R6: reset state
    chk(frame_out == 1'b1, "R6", frame_out, 1);
    chk(width_rd == 8'h01, "R6", width_rd, 1);
    rst_n = 1'b1;

    // R2: square wave for two frames
    repeat (2 * P + 2) cycle(1'b0, 8'h00, 2'b00);

    // R4: zero maps to one; R5: upper nibble dropped
    cycle(1'b1, 8'hF0, 2'b00);
    chk(width_rd == 8'h01, "R4", width_rd, 1);
    cycle(1'b1, 8'hA7, 2'b00);
    chk(width_rd == 8'h07, "R5", width_rd, 7);

    // R3: pulse width 7, then maximum 15
    run_to(P - 2, 2'b01);
    repeat (P + 4) cycle(1'b0, 8'h00, 2'b01);
    cycle(1'b1, 8'h0F, 2'b01);
    run_to(0, 2'b01);
    repeat (2 * P) cycle(1'b0, 8'h00, 2'b01);

    // R7: mid-frame width and shape change
    run_to(2, 2'b01);
    cycle(1'b1, 8'h03, 2'b01);
    repeat (20) cycle(1'b0, 8'h00, 2'b00);
    run_to(0, 2'b01);
    repeat (P) cycle(1'b0, 8'h00, 2'b01);

    // R8: spare codes give square
    repeat (P + 2) cycle(1'b0, 8'h00, 2'b10);
    repeat (P + 2) cycle(1'b0, 8'h00, 2'b11);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we;
      we = ($urandom % 16) == 0;
      cycle(we, 8'($urandom), 2'($urandom));
    end

    // R6: reset mid-frame
    run_to(20, 2'b01);
    rst_n = 1'b0;
    #1;
    chk(frame_out == 1'b1, "R6", frame_out, 1);
    chk(width_rd == 8'h01, "R6", width_rd, 1);
    @(negedge clk_sync);
    model_reset();
    rst_n = 1'b1;
    repeat (P + 5) cycle(1'b0, 8'h00, 2'b01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule